// File: doc/BRIEF.md
# I2C Clock Prescale Calculator

This block turns a system clock frequency, given in units of 10 kHz, into the 16-bit prescale word that an I2C engine needs to set its bit timing. A two-bit mode input selects the formula. The search mode scans upward for the first divisor whose quotient falls below the divisor itself, and then packs a pair of derived bytes. The two fixed modes each place a computed byte next to a constant byte. The fourth mode code yields a zero word.

The caller pulses `start_i` while the block is idle. The block captures the frequency and the mode on that edge and raises `busy_o`. It then runs every division through one shared restoring divider that produces one quotient bit per cycle. When the result is ready it pulses `done_o` for one cycle, and the word and the overflow flag stay fixed until the next result.

Top module: `presc_calc`

## Requirements
- R1: While reset is active and in the first cycle after it, `prescale_o`, `overflow_o`, `done_o` and `busy_o` are all 0.
- R2: `start_i` is accepted only when `busy_o` is low, and the mode and frequency are captured on that edge. A `start_i` pulse while `busy_o` is high has no effect on any later result.
- R3: Mode code 2'b00 (search) computes nm = floor(sclk*10/240) and finds the smallest L in 1..254 with floor(nm/L) < L. The word carries L-2 (mod 256) in bits 7:0 and L-1 in bits 15:8, so nm = 0 gives 16'h00FF.
- R4: In search mode, if no L up to 254 meets the condition, L is taken as 255 (word 16'hFEFD) and `overflow_o` is 1. Every other result clears `overflow_o` to 0.
- R5: Mode code 2'b01 (step) gives bits 15:8 = (floor(sclk*10/51200) + 1) mod 256 and bits 7:0 = 8'h80.
- R6: Mode code 2'b10 (fixed high) gives (16'h7F00 + floor(sclk*10/25400)) mod 65536.
- R7: Mode code 2'b11 gives a zero word with `overflow_o` 0 and still pulses `done_o`.
- R8: `done_o` is high for exactly one cycle per accepted start. `prescale_o` and `overflow_o` change only in a cycle where `done_o` is high and hold their values otherwise.
- R9: `busy_o` is high from the cycle after an accepted start and falls in the cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a calculation (honoured when idle) |
| mode_i | input | 2 | Formula select: 00 search, 01 step, 10 fixed high, 11 none |
| sclk_i | input | SCLK_W | System clock frequency in 10 kHz units |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result strobe |
| prescale_o | output | 16 | Prescale word, held between results |
| overflow_o | output | 1 | Search ended without meeting its condition |

## Verification
The bench builds the block with SCLK_W = 22 in place of the default 16. At the default width nm never exceeds a few thousand, so the search always ends near L = 52 and can never run out of divisors. With 22 bits the bench can place nm exactly at 64515 and 64516, the two values on either side of the overflow boundary, and can drive the full 254-step search. The wider input also reaches the byte wrap of the step mode at a quotient of 255 and the carry into the upper byte in the fixed-high mode.

// File: rtl/presc_pkg.sv
package presc_pkg;

   typedef enum logic [1:0] {
      PM_SEARCH = 2'b00,
      PM_STEP   = 2'b01,
      PM_FIXHI  = 2'b10,
      PM_NONE   = 2'b11
   } presc_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BASE_GO,
      ST_BASE_WAIT,
      ST_STEP_GO,
      ST_STEP_WAIT
   } presc_state_e;

endpackage

// File: rtl/presc_div.sv
// Restoring unsigned divider, one quotient bit per clock.
module presc_div #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         valid_o,
   output logic [W-1:0] quot_o
);
   localparam int CW = $clog2(W + 1);

   if (W < 2) begin : g_bad_width
      $error("presc_div: W must be at least 2");
   end

   logic [W-1:0]  rem_q, quo_q, den_q;
   logic [CW-1:0] cnt_q;
   logic          run_q, valid_q;
   logic [W:0]    shifted, trial;
   logic          fits;

   always_comb begin
      shifted = {rem_q, quo_q[W-1]};
      trial   = shifted - {1'b0, den_q};
      fits    = ~trial[W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q   <= '0;
         quo_q   <= '0;
         den_q   <= '0;
         cnt_q   <= '0;
         run_q   <= 1'b0;
         valid_q <= 1'b0;
      end else if (go_i) begin
         rem_q   <= '0;
         quo_q   <= num_i;
         den_q   <= den_i;
         cnt_q   <= CW'(W);
         run_q   <= 1'b1;
         valid_q <= 1'b0;
      end else if (run_q) begin
         rem_q   <= fits ? trial[W-1:0] : shifted[W-1:0];
         quo_q   <= {quo_q[W-2:0], fits};
         cnt_q   <= cnt_q - CW'(1);
         run_q   <= (cnt_q != CW'(1));
         valid_q <= (cnt_q == CW'(1));
      end else begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign quot_o  = quo_q;

   // R3
   div_go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> !run_q);

   // R3
   div_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

endmodule

// File: rtl/presc_pack.sv
// Assembles the 16-bit word for each formula.
module presc_pack
   import presc_pkg::*;
#(
   parameter int NUM_W      = 20,
   parameter int STEP_LOW   = 128,
   parameter int FIXHI_BYTE = 127
) (
   input  presc_mode_e      mode_i,
   input  logic [NUM_W-1:0] quot_i,
   input  logic [7:0]       loop_i,
   output logic [15:0]      word_o
);
   if (NUM_W < 16) begin : g_bad_num
      $error("presc_pack: NUM_W must be at least 16");
   end
   if (STEP_LOW > 255 || FIXHI_BYTE > 255) begin : g_bad_const
      $error("presc_pack: constant bytes must fit in 8 bits");
   end

   logic [7:0] n_byte, m_byte;

   always_comb begin
      n_byte = loop_i - 8'd1;
      m_byte = loop_i - 8'd2;
      unique case (mode_i)
         PM_SEARCH: word_o = {n_byte, m_byte};
         PM_STEP:   word_o = 16'(((quot_i + NUM_W'(1)) << 8) + NUM_W'(STEP_LOW));
         PM_FIXHI:  word_o = 16'(quot_i + NUM_W'(FIXHI_BYTE * 256));
         default:   word_o = 16'h0000;
      endcase
   end

endmodule

// File: rtl/presc_calc.sv
// Sequential I2C prescale calculator, top level.
module presc_calc
   import presc_pkg::*;
#(
   parameter int SCLK_W       = 16,
   parameter int LOOP_LIMIT   = 255,
   parameter int RATE_SEARCH  = 60,
   parameter int RATE_FIXHI   = 50,
   parameter int STEP_DEN     = 51200,
   parameter int STEP_LOW     = 128,
   parameter int FIXHI_BYTE   = 127
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic [SCLK_W-1:0] sclk_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [15:0]       prescale_o,
   output logic              overflow_o
);
   localparam int NUM_W      = SCLK_W + 4;
   localparam int PW         = 2 * NUM_W;
   localparam int DEN_SEARCH = 4 * RATE_SEARCH;
   localparam int DEN_FIXHI  = 4 * FIXHI_BYTE * RATE_FIXHI;

   if (SCLK_W < 12) begin : g_bad_sclk
      $error("presc_calc: SCLK_W must be at least 12");
   end
   if (LOOP_LIMIT < 3 || LOOP_LIMIT > 255) begin : g_bad_limit
      $error("presc_calc: LOOP_LIMIT must lie in 3..255");
   end
   if ($clog2(STEP_DEN + 1) > NUM_W || $clog2(DEN_FIXHI + 1) > NUM_W) begin : g_bad_den
      $error("presc_calc: divisor constants exceed the numerator width");
   end

   presc_state_e      state_q;
   presc_mode_e       mode_q;
   logic [SCLK_W-1:0] sclk_q;
   logic [NUM_W-1:0]  nm_q;
   logic [7:0]        loop_q;
   logic [15:0]       word_q;
   logic              ovf_q, done_q;

   logic [NUM_W-1:0]  scaled, base_den, div_num, div_den, div_quot;
   logic              div_go, div_valid, in_step, found, last_step;
   logic [7:0]        fin_loop;
   logic [15:0]       pack_word;

   always_comb begin
      scaled = ({4'd0, sclk_q} << 3) + ({4'd0, sclk_q} << 1);
      unique case (mode_q)
         PM_SEARCH: base_den = NUM_W'(DEN_SEARCH);
         PM_STEP:   base_den = NUM_W'(STEP_DEN);
         PM_FIXHI:  base_den = NUM_W'(DEN_FIXHI);
         default:   base_den = NUM_W'(1);
      endcase
      in_step   = (state_q == ST_STEP_GO) || (state_q == ST_STEP_WAIT);
      div_num   = in_step ? nm_q : scaled;
      div_den   = in_step ? NUM_W'(loop_q) : base_den;
      div_go    = ((state_q == ST_BASE_GO) && (mode_q != PM_NONE)) ||
                  (state_q == ST_STEP_GO);
      found     = div_quot < NUM_W'(loop_q);
      last_step = loop_q == 8'(LOOP_LIMIT - 1);
      fin_loop  = found ? loop_q : 8'(LOOP_LIMIT);
   end

   presc_div #(.W(NUM_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (div_go),
      .num_i   (div_num),
      .den_i   (div_den),
      .valid_o (div_valid),
      .quot_o  (div_quot)
   );

   presc_pack #(
      .NUM_W      (NUM_W),
      .STEP_LOW   (STEP_LOW),
      .FIXHI_BYTE (FIXHI_BYTE)
   ) u_pack (
      .mode_i (mode_q),
      .quot_i (div_quot),
      .loop_i (fin_loop),
      .word_o (pack_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= PM_SEARCH;
         sclk_q  <= '0;
         nm_q    <= '0;
         loop_q  <= 8'd1;
         word_q  <= '0;
         ovf_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mode_q  <= presc_mode_e'(mode_i);
                  sclk_q  <= sclk_i;
                  state_q <= ST_BASE_GO;
               end
            end
            ST_BASE_GO: begin
               if (mode_q == PM_NONE) begin
                  word_q  <= 16'h0000;
                  ovf_q   <= 1'b0;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  state_q <= ST_BASE_WAIT;
               end
            end
            ST_BASE_WAIT: begin
               if (div_valid) begin
                  if (mode_q == PM_SEARCH) begin
                     nm_q    <= div_quot;
                     loop_q  <= 8'd1;
                     state_q <= ST_STEP_GO;
                  end else begin
                     word_q  <= pack_word;
                     ovf_q   <= 1'b0;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_STEP_GO: state_q <= ST_STEP_WAIT;
            ST_STEP_WAIT: begin
               if (div_valid) begin
                  if (found || last_step) begin
                     word_q  <= pack_word;
                     ovf_q   <= ~found;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     loop_q  <= loop_q + 8'd1;
                     state_q <= ST_STEP_GO;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign prescale_o = word_q;
   assign overflow_o = ovf_q;

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(prescale_o) && $stable(overflow_o)));

   // R2
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(sclk_q) && $stable(mode_q)));

   // R9
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R4
   ovf_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow_o) |-> (done_o &&
         prescale_o == {8'(LOOP_LIMIT - 1), 8'(LOOP_LIMIT - 2)}));

   // R3
   div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_valid |-> ((PW'(div_quot) * PW'(div_den) <= PW'(div_num)) &&
                     (PW'(div_num) - PW'(div_quot) * PW'(div_den) < PW'(div_den))));

endmodule

// File: tb/presc_calc_test.sv
module presc_calc_test;
   localparam int CLK_PERIOD = 10;
   localparam int SW         = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    mode = 2'b00;
   logic [SW-1:0] sclk = '0;
   logic          busy, done, ovf;
   logic [15:0]   word;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [15:0] q_word[$];
   logic        q_ovf[$];
   string       q_tag[$];

   logic        prev_done = 1'b0;
   logic [15:0] last_word = '0;
   logic        last_ovf = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   presc_calc #(.SCLK_W(SW)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .mode_i     (mode),
      .sclk_i     (sclk),
      .busy_o     (busy),
      .done_o     (done),
      .prescale_o (word),
      .overflow_o (ovf)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic void model(input int m, input longint s,
                                 output logic [15:0] w, output logic o);
      longint x;
      longint nm;
      longint l;
      x = s * 10;
      o = 1'b0;
      w = 16'h0000;
      case (m)
         0: begin
            nm = x / 240;
            l = 1;
            while (l < 255 && !((nm / l) < l)) l++;
            o = (l == 255);
            w = {8'(l - 1), 8'(l - 2)};
         end
         1: w = {8'(x / 51200 + 1), 8'h80};
         2: w = 16'(longint'(16'h7F00) + x / 25400);
         default: w = 16'h0000;
      endcase
   endfunction

   task automatic issue(input int m, input longint s, input string tag);
      logic [15:0] ew;
      logic        eo;
      while (busy) @(negedge clk);
      model(m, s, ew, eo);
      q_word.push_back(ew);
      q_ovf.push_back(eo);
      q_tag.push_back(tag);
      mode  = 2'(m);
      sclk  = SW'(s);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R9", "busy after start", longint'(busy), 1);
   endtask

   // Monitor: pops expected results as done strobes appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (q_word.size() == 0) begin
               check(1'b0, "R2", "unexpected done", 1, 0);
            end else begin
               logic [15:0] ew;
               logic        eo;
               string       tg;
               ew = q_word.pop_front();
               eo = q_ovf.pop_front();
               tg = q_tag.pop_front();
               check(word == ew, tg, "prescale word", longint'(word), longint'(ew));
               check(ovf == eo, "R4", "overflow flag", longint'(ovf), longint'(eo));
               check(busy == 1'b0, "R9", "busy at done", longint'(busy), 0);
            end
         end else if (word != last_word || ovf != last_ovf) begin
            check(1'b0, "R8", "output moved without done", longint'(word), longint'(last_word));
         end
         if (prev_done && done)
            check(1'b0, "R8", "done wider than one cycle", 2, 1);
      end
      prev_done = done;
      last_word = word;
      last_ovf  = ovf;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(word == 16'h0000, "R1", "reset word", longint'(word), 0);
      check(ovf == 1'b0, "R1", "reset overflow", longint'(ovf), 0);
      check(done == 1'b0, "R1", "reset done", longint'(done), 0);
      check(busy == 1'b0, "R1", "reset busy", longint'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(word == 16'h0000 && busy == 1'b0, "R1", "first cycle after reset", longint'(word), 0);

      // R3: search mode, several frequencies
      issue(0, 0, "R3");
      issue(0, 100, "R3");
      issue(0, 1600, "R3");
      issue(0, 65535, "R3");
      issue(0, 1548360, "R3");      // nm = 64515, last step that succeeds
      // R4: search runs out at the boundary and beyond
      issue(0, 1548384, "R4");      // nm = 64516
      issue(0, 4194303, "R4");
      issue(0, 240, "R4");          // overflow clears again
      // R5: step mode, including the byte wrap
      issue(1, 0, "R5");
      issue(1, 40000, "R5");
      issue(1, 1305600, "R5");
      // R6: fixed-high mode, including carry into the upper byte
      issue(2, 5000, "R6");
      issue(2, 4194303, "R6");
      // R7: unused mode code
      issue(3, 12345, "R7");

      // R2: start while busy is ignored
      issue(0, 4194303, "R2");
      repeat (5) @(negedge clk);
      mode  = 2'b01;
      sclk  = SW'(5);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R2", "still busy after ignored start", longint'(busy), 1);
      issue(2, 254, "R6");

      while (busy || q_word.size() != 0) @(negedge clk);
      repeat (5) @(negedge clk);
      check(q_word.size() == 0, "R8", "results outstanding", q_word.size(), 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R9 watchdog expired actual 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule